// File: doc/BRIEF.md
# EEPROM Write Control Unit

This block is the write half of a small serial EEPROM. A serial front end decodes the bus traffic and passes it in as one-cycle requests: set the write-enable latch, arm its clearing, write the protection field of the status register, open a memory write at an address, and push data bytes. The block also receives a pulse when chip select goes high, with a flag that says whether the frame ended on a byte boundary. On that pulse it decides whether the pending write may go ahead. If it may, it runs a self-timed program cycle of a fixed number of clocks and then commits the page data or the new protection field.

The array is a byte-wide RAM of `2**ADDR_W` entries. It comes up filled with FFh, and neither it nor the two protection bits are touched by reset, which models nonvolatile storage. A registered read port serves the front end's array reads. The status byte is always available for readback, including while a program cycle is running.

Top module: `eeprom_wr_ctrl`

## Requirements
- R1: `status_o` is laid out as bits 7:4 = 1111, bits 3:2 = protection field, bit 1 = write-enable latch, bit 0 = write in progress. After the first reset it reads F0h.
- R2: `wren_i` sets the latch in the next cycle. `wrdi_i` clears nothing by itself; the latch clears on the next `sel_rise_i`.
- R3: A memory or status write attempted while the latch is clear is dropped: the array is unchanged and bit 0 stays 0.
- R4: If `wp_ni` is low when `sel_rise_i` arrives, both memory and status writes are refused.
- R5: Protection field 01 locks addresses 180h-1FFh, 10 locks 100h-1FFh and 11 locks the whole array; 00 locks nothing. A write to a locked page leaves the array unchanged and does not raise bit 0.
- R6: A page holds `PAGE_BYTES` (16) bytes. Bytes are placed from the offset `wr_addr_i[3:0]` upward and wrap to offset 0 of the same page. A later byte in the same slot replaces an earlier one.
- R7: A write commits only on `sel_rise_i` with `frame_ok_i` high and, for a memory write, with at least one byte loaded. Otherwise it is discarded.
- R8: Bit 0 is high for exactly `PROG_CYCLES` cycles, starting in the cycle after the committing edge. The latch is clear when the cycle ends.
- R9: While bit 0 is high, every request except status readback is ignored. This covers latch requests, writes and array reads; `rd_data_o` holds its value.
- R10: A committed status write loads `bp_wr_i` into bits 3:2 when the program cycle ends, and not before.
- R11: `rst_ni` clears the latch and any cycle in progress but keeps the protection field and the array contents.
- R12: `rd_en_i` returns the byte at `rd_addr_i` on `rd_data_o` one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wp_ni | input | 1 | Write-protect pin, low refuses writes |
| sel_rise_i | input | 1 | Chip select returned high (frame end) |
| frame_ok_i | input | 1 | Frame ended on a byte boundary |
| wren_i | input | 1 | Set the write-enable latch |
| wrdi_i | input | 1 | Clear the latch at frame end |
| wrsr_i | input | 1 | Status write request |
| bp_wr_i | input | 2 | Protection field carried by the status write |
| wr_start_i | input | 1 | Open a memory write |
| wr_addr_i | input | ADDR_W | Start address of the memory write |
| wr_byte_i | input | 1 | Data byte strobe |
| wr_data_i | input | 8 | Data byte |
| rd_en_i | input | 1 | Array read request |
| rd_addr_i | input | ADDR_W | Array read address |
| rd_data_o | output | 8 | Array read data, one cycle after request |
| status_o | output | 8 | Status byte |

## Verification
The embedded properties watch on every cycle that a program cycle starts only from a set latch, a high protect pin and an unlocked page. They also check that the latch is clear whenever a cycle ends, that the protection field changes only at the end of a cycle, and that the busy counter advances without gaps. What actually lands in the array can only be shown by the bench's scenarios: page wrap, overwriting of slots, byte-aligned frame ends, the exact busy length, requests ignored while busy, and survival of data and protection across reset. The bench shows these by reading bytes back and comparing them with values it predicts itself.

// File: rtl/eewr_pkg.sv
package eewr_pkg;
  typedef enum logic [1:0] {OP_NONE, OP_STATUS, OP_MEM} op_e;

  // top2 = two most significant address bits of the page
  function automatic logic addr_locked(input logic [1:0] bp, input logic [1:0] top2);
    case (bp)
      2'b01:   return top2 == 2'b11;
      2'b10:   return top2[1];
      2'b11:   return 1'b1;
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/eewr_prog_timer.sv
module eewr_prog_timer #(
  parameter int PROG_CYCLES = 1000000,
  parameter int PAGE_BYTES  = 16,
  localparam int CNT_W = $clog2(PROG_CYCLES + 1),
  localparam int OFF_W = $clog2(PAGE_BYTES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             slot_vld_o,
  output logic [OFF_W-1:0] slot_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PROG_CYCLES - 1);
  localparam logic [CNT_W-1:0] NSLOT = CNT_W'(PAGE_BYTES);

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end
    end else if (cnt_q == LAST) begin
      busy_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign busy_o     = busy_q;
  assign done_o     = busy_q && (cnt_q == LAST);
  assign slot_vld_o = busy_q && (cnt_q < NSLOT);
  assign slot_o     = cnt_q[OFF_W-1:0];

  assert_busy_span_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && cnt_q != '0) |-> ($past(busy_q) && cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/eewr_page_buf.sv
module eewr_page_buf #(
  parameter int PAGE_BYTES = 16,
  localparam int OFF_W = $clog2(PAGE_BYTES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic             push_i,
  input  logic [7:0]       data_i,
  input  logic [OFF_W-1:0] slot_i,
  output logic [7:0]       slot_data_o,
  output logic             slot_vld_o,
  output logic             any_o
);
  logic [OFF_W-1:0]      ptr_q;
  logic [PAGE_BYTES-1:0] mask_q;
  logic [7:0]            buf_q [PAGE_BYTES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q  <= '0;
      mask_q <= '0;
    end else if (clear_i) begin
      ptr_q  <= off_i;
      mask_q <= '0;
    end else if (push_i) begin
      ptr_q         <= ptr_q + 1'b1;  // wraps inside the page
      mask_q[ptr_q] <= 1'b1;
    end
  end

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
    always_ff @(posedge clk_i) begin
      if (push_i && !clear_i && ptr_q == OFF_W'(g)) buf_q[g] <= data_i;
    end
  end

  assign slot_data_o = buf_q[slot_i];
  assign slot_vld_o  = mask_q[slot_i];
  assign any_o       = |mask_q;

  assert_push_marks_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !clear_i) |=> any_o);
endmodule

// File: rtl/eewr_array.sv
module eewr_array #(
  parameter int ADDR_W = 9,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [7:0]        wdata_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [7:0]        rdata_o
);
  // delivery content; no reset (nonvolatile)
  logic [7:0] mem_q [DEPTH] = '{default: 8'hFF};
  logic [7:0] rdata_q;

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (re_i) rdata_q <= mem_q[raddr_i];
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/eeprom_wr_ctrl.sv
module eeprom_wr_ctrl
  import eewr_pkg::*;
#(
  parameter int ADDR_W      = 9,
  parameter int PAGE_BYTES  = 16,
  parameter int PROG_CYCLES = 1000000,
  localparam int OFF_W  = $clog2(PAGE_BYTES),
  localparam int PAGE_W = ADDR_W - OFF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wp_ni,
  input  logic              sel_rise_i,
  input  logic              frame_ok_i,
  input  logic              wren_i,
  input  logic              wrdi_i,
  input  logic              wrsr_i,
  input  logic [1:0]        bp_wr_i,
  input  logic              wr_start_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic              wr_byte_i,
  input  logic [7:0]        wr_data_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [7:0]        rd_data_o,
  output logic [7:0]        status_o
);
  logic              wel_q, wrdi_pend_q;
  op_e               op_q, run_op_q;
  logic [1:0]        bp_new_q;
  logic [PAGE_W-1:0] page_q;
  logic [1:0]        bp_q = 2'b00;  // nonvolatile, delivery value

  logic busy, done, slot_vld, any, buf_vld, idle, locked, can_commit;
  logic commit_sr, commit_mem, start;
  logic [OFF_W-1:0] slot;
  logic [7:0]       slot_data;

  assign idle       = !busy;
  assign locked     = addr_locked(bp_q, page_q[PAGE_W-1 -: 2]);
  assign can_commit = idle && sel_rise_i && frame_ok_i && wel_q && wp_ni;
  assign commit_sr  = can_commit && (op_q == OP_STATUS);
  assign commit_mem = can_commit && (op_q == OP_MEM) && any && !locked;
  assign start      = commit_sr || commit_mem;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wel_q       <= 1'b0;
      wrdi_pend_q <= 1'b0;
      op_q        <= OP_NONE;
      run_op_q    <= OP_NONE;
      bp_new_q    <= '0;
      page_q      <= '0;
    end else if (done) begin
      wel_q <= 1'b0;
    end else if (idle) begin
      if (sel_rise_i) begin
        if (wrdi_pend_q) wel_q <= 1'b0;
        wrdi_pend_q <= 1'b0;
        op_q        <= OP_NONE;
        if (start) run_op_q <= commit_sr ? OP_STATUS : OP_MEM;
      end else begin
        if (wren_i) wel_q <= 1'b1;
        if (wrdi_i) wrdi_pend_q <= 1'b1;
        if (wrsr_i) begin
          op_q     <= OP_STATUS;
          bp_new_q <= bp_wr_i;
        end else if (wr_start_i) begin
          op_q   <= OP_MEM;
          page_q <= wr_addr_i[ADDR_W-1:OFF_W];
        end
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (done && run_op_q == OP_STATUS) bp_q <= bp_new_q;
  end

  eewr_prog_timer #(.PROG_CYCLES(PROG_CYCLES), .PAGE_BYTES(PAGE_BYTES)) u_timer (
    .clk_i, .rst_ni, .start_i(start), .busy_o(busy), .done_o(done),
    .slot_vld_o(slot_vld), .slot_o(slot)
  );

  eewr_page_buf #(.PAGE_BYTES(PAGE_BYTES)) u_buf (
    .clk_i, .rst_ni,
    .clear_i(idle && !sel_rise_i && wr_start_i && !wrsr_i),
    .off_i(wr_addr_i[OFF_W-1:0]),
    .push_i(idle && !sel_rise_i && wr_byte_i && op_q == OP_MEM),
    .data_i(wr_data_i), .slot_i(slot),
    .slot_data_o(slot_data), .slot_vld_o(buf_vld), .any_o(any)
  );

  eewr_array #(.ADDR_W(ADDR_W)) u_array (
    .clk_i, .rst_ni,
    .we_i(slot_vld && buf_vld && run_op_q == OP_MEM),
    .waddr_i({page_q, slot}), .wdata_i(slot_data),
    .re_i(rd_en_i && idle), .raddr_i(rd_addr_i), .rdata_o(rd_data_o)
  );

  assign status_o = {4'hF, bp_q, wel_q, busy};

  assert_wel_gate_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> $past(wel_q));
  assert_wp_gate_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> $past(wp_ni));
  assert_lock_gate_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(busy) && run_op_q == OP_MEM) |-> !$past(locked));
  assert_wel_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy) |-> !wel_q);
  assert_bp_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(bp_q) |-> $fell(busy));
endmodule

// File: tb/sim_eeprom_wr_ctrl.sv
module sim_eeprom_wr_ctrl;
  localparam int P = 40;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wp_n = 1'b1, sel_rise = 1'b0, frame_ok = 1'b0;
  logic wren = 1'b0, wrdi = 1'b0, wrsr = 1'b0, wr_start = 1'b0, wr_byte = 1'b0, rd_en = 1'b0;
  logic [1:0] bp_wr = '0;
  logic [8:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0, rd_data, status;

  always #2.5 clk = ~clk;

  eeprom_wr_ctrl #(.ADDR_W(9), .PAGE_BYTES(16), .PROG_CYCLES(P)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .wp_ni(wp_n), .sel_rise_i(sel_rise), .frame_ok_i(frame_ok),
    .wren_i(wren), .wrdi_i(wrdi), .wrsr_i(wrsr), .bp_wr_i(bp_wr), .wr_start_i(wr_start),
    .wr_addr_i(wr_addr), .wr_byte_i(wr_byte), .wr_data_i(wr_data), .rd_en_i(rd_en),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .status_o(status)
  );

  int checks = 0, errors = 0;

  typedef struct { logic [7:0] exp; string req; } rd_item_t;
  rd_item_t sb_q[$];
  logic rd_track = 1'b0, mon_arm = 1'b0;

  task automatic check8(input logic [7:0] act, input logic [7:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(posedge clk) mon_arm <= rd_en && rd_track;
  always @(negedge clk) begin
    if (mon_arm && sb_q.size() > 0) begin
      rd_item_t it;
      it = sb_q.pop_front();
      check8(rd_data, it.exp, it.req);
    end
  end

  task automatic report;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  task automatic do_wren;  @(negedge clk) wren = 1; @(negedge clk) wren = 0; endtask
  task automatic do_wrdi;  @(negedge clk) wrdi = 1; @(negedge clk) wrdi = 0; endtask

  task automatic frame_end(input logic ok, input logic wp);
    @(negedge clk) begin sel_rise = 1; frame_ok = ok; wp_n = wp; end
    @(negedge clk) begin sel_rise = 0; frame_ok = 0; wp_n = 1; end
  endtask

  task automatic page_load(input logic [8:0] a, input int n, input logic [7:0] base, input logic [7:0] step);
    @(negedge clk) begin wr_start = 1; wr_addr = a; end
    @(negedge clk) wr_start = 0;
    for (int i = 0; i < n; i++) begin
      wr_byte = 1; wr_data = base + 8'(i) * step;
      @(negedge clk);
    end
    wr_byte = 0;
  endtask

  task automatic wait_done(output int n);
    n = 0;
    while (status[0] && n < 4 * P) begin n++; @(negedge clk); end
  endtask

  task automatic do_read(input logic [8:0] a, input logic [7:0] exp, input string req);
    rd_item_t it;
    it.exp = exp; it.req = req;
    sb_q.push_back(it);
    @(negedge clk) begin rd_en = 1; rd_addr = a; rd_track = 1; end
    @(negedge clk) begin rd_en = 0; rd_track = 0; end
  endtask

  task automatic status_write(input logic [1:0] bp, input logic wp);
    int n;
    do_wren(); frame_end(1, 1);
    @(negedge clk) begin wrsr = 1; bp_wr = bp; end
    @(negedge clk) wrsr = 0;
    frame_end(1, wp);
    wait_done(n);
  endtask

  initial begin
    int n;
    logic [7:0] held;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check8(status, 8'hF0, "R1 reset status");
    do_read(9'h000, 8'hFF, "R11 delivery content low");
    do_read(9'h1FF, 8'hFF, "R11 delivery content high");

    // R3: no latch
    page_load(9'h010, 1, 8'hAA, 8'h00);
    frame_end(1, 1);
    check8({7'b0, status[0]}, 8'h00, "R3 no busy without latch");
    do_read(9'h010, 8'hFF, "R3 array unchanged");

    // R2
    do_wren();
    check8(status, 8'hF2, "R2 latch set");
    do_wrdi();
    check8(status, 8'hF2, "R2 latch held until frame end");
    frame_end(0, 1);
    check8(status, 8'hF0, "R2 latch cleared at frame end");

    // R6/R8: wrap inside page
    do_wren(); frame_end(1, 1);
    page_load(9'h02E, 3, 8'h11, 8'h11);
    frame_end(1, 1);
    wait_done(n);
    check8(8'(n), 8'(P), "R8 busy length");
    check8(status, 8'hF0, "R8 latch clear after cycle");
    do_read(9'h02E, 8'h11, "R6 first byte");
    do_read(9'h02F, 8'h22, "R6 page end");
    do_read(9'h020, 8'h33, "R6 wrap to page start");
    do_read(9'h021, 8'hFF, "R6 untouched slot");

    // R6 overflow + R9 ignore while busy
    do_wren(); frame_end(1, 1);
    page_load(9'h040, 17, 8'h80, 8'h01);
    held = rd_data;
    frame_end(1, 1);
    do_wren();
    @(negedge clk) begin rd_en = 1; rd_addr = 9'h02E; end
    @(negedge clk) rd_en = 0;
    check8(rd_data, held, "R9 read ignored while busy");
    page_load(9'h050, 1, 8'h5A, 8'h00);
    frame_end(1, 1);
    wait_done(n);
    check8(status, 8'hF0, "R9 latch request ignored while busy");
    do_read(9'h040, 8'h90, "R6 overwrite by 17th byte");
    do_read(9'h041, 8'h81, "R6 second slot");
    do_read(9'h04F, 8'h8F, "R6 last slot");
    do_read(9'h050, 8'hFF, "R9 write ignored while busy");

    // R7
    do_wren(); frame_end(1, 1);
    page_load(9'h060, 1, 8'h55, 8'h00);
    frame_end(0, 1);
    check8(status, 8'hF2, "R7 misaligned frame no commit");
    page_load(9'h061, 0, 8'h00, 8'h00);
    frame_end(1, 1);
    check8(status, 8'hF2, "R7 empty page no commit");
    do_read(9'h060, 8'hFF, "R7 array unchanged");

    // R4
    page_load(9'h070, 1, 8'h66, 8'h00);
    frame_end(1, 0);
    check8({7'b0, status[0]}, 8'h00, "R4 memory write refused");
    do_read(9'h070, 8'hFF, "R4 array unchanged");
    status_write(2'b11, 1'b0);
    check8(status & 8'hFC, 8'hF0, "R4 status write refused");
    do_wrdi(); frame_end(0, 1);

    // R10 + R5 field 01
    do_wren(); frame_end(1, 1);
    @(negedge clk) begin wrsr = 1; bp_wr = 2'b01; end
    @(negedge clk) wrsr = 0;
    frame_end(1, 1);
    check8(status, 8'hF3, "R10 field unchanged during cycle");
    wait_done(n);
    check8(status, 8'hF4, "R10 field loaded at cycle end");
    do_wren(); frame_end(1, 1);
    page_load(9'h180, 1, 8'h01, 8'h00);
    frame_end(1, 1);
    check8({7'b0, status[0]}, 8'h00, "R5 01 locks 180h");
    do_read(9'h180, 8'hFF, "R5 locked byte unchanged");
    page_load(9'h17F, 1, 8'h7F, 8'h00);
    frame_end(1, 1);
    wait_done(n);
    do_read(9'h17F, 8'h7F, "R5 01 leaves 17Fh open");

    // R5 field 10
    status_write(2'b10, 1'b1);
    do_wren(); frame_end(1, 1);
    page_load(9'h100, 1, 8'h02, 8'h00);
    frame_end(1, 1);
    check8({7'b0, status[0]}, 8'h00, "R5 10 locks 100h");
    page_load(9'h0FF, 1, 8'hC3, 8'h00);
    frame_end(1, 1);
    wait_done(n);
    do_read(9'h0FF, 8'hC3, "R5 10 leaves 0FFh open");

    // R5 field 11
    status_write(2'b11, 1'b1);
    do_wren(); frame_end(1, 1);
    page_load(9'h000, 1, 8'h03, 8'h00);
    frame_end(1, 1);
    check8({7'b0, status[0]}, 8'h00, "R5 11 locks all");
    do_read(9'h000, 8'hFF, "R5 11 array unchanged");

    // R11 reset keeps field and data
    @(negedge clk) rst_n = 0;
    @(negedge clk) rst_n = 1;
    @(negedge clk);
    check8(status, 8'hFC, "R11 field kept, latch cleared");
    do_read(9'h02E, 8'h11, "R11 array kept");
    status_write(2'b00, 1'b1);
    check8(status, 8'hF0, "R1 field cleared");

    repeat (2) @(negedge clk);
    if (sb_q.size() != 0) check8(8'(sb_q.size()), 8'h00, "R12 reads all answered");
    report();
  end
endmodule